// File: doc/BRIEF.md
# Host-Card Control and Interrupt Register

This block is the single byte-wide control and status register that sits between a host bus and an embedded channel processor. The host uses it to start and stop the channel processor and to open or close the shared-memory window. It also reads back whether a watchdog timeout has stopped the processor. Two one-bit doorbells pass interrupts across the boundary. The card raises a flag toward the host, and the host acknowledges it by writing a one. The host raises a flag toward the card, and the card's service strobe lowers it.

The host port is a plain write strobe with write data, and a read-data bus that always shows the current register contents. On the card side there is one strobe that raises the host-bound flag and one that lowers the card-bound flag. A single-cycle watchdog-expired pulse comes in from an external timer. The block drives four outputs: the host interrupt pin, whose active level is chosen by a configuration input; a processor halt line; a shared-memory decode enable; and a health LED override. Each time the run bit is cleared, the halt line is held for a parameterised minimum number of clocks, so the processor always receives a reset pulse of at least that length.

Top module: `hostcard_ctrl_reg`

## Requirements
- R1: After reset, the read data is 0x00, `cpu_halt` and `led_force_red` are 1, `mem_decode_en` and `card_irq` are 0, and the interrupt pin is at its inactive level.
- R2: Read data layout. Bit 7 is run, bit 6 is memory enable, bit 5 is interrupt enable, bit 4 is watchdog status, bit 2 is the card-to-host flag and bit 0 is the host-to-card flag. Bits 3 and 1 always read 0. A host write loads bits 7, 6 and 5 on the next clock, and the written values of bits 4, 3 and 1 are ignored.
- R3: `mem_decode_en` equals the memory enable bit.
- R4: While run is 0, `cpu_halt` and `led_force_red` are 1. While run is 1 with no watchdog status and no hold pending, both are 0.
- R5: A `wdog_expired` pulse while run is 1 sets the watchdog status and halts the processor from the next clock. Writing run=1 does not clear it. Writing run=0 clears it on the next clock. A pulse while run is 0 is ignored.
- R6: After run goes from 1 to 0, and after reset, `cpu_halt` stays 1 for at least `HALT_MIN_CYCLES` clocks even if run is written back to 1 sooner. While run is 1 and this hold is pending, the watchdog status bit reads 1.
- R7: `card_raise_host_irq` sets bit 2 on the next clock. A host write with bit 2 = 1 clears it, and a write with bit 2 = 0 leaves it unchanged. If a raise and an acknowledge arrive in the same cycle, the raise wins.
- R8: A host write with bit 0 = 1 sets bit 0 and `card_irq` on the next clock, and a write with bit 0 = 0 has no effect. `card_ack_card_irq` clears the flag. If both arrive in the same cycle, the host set wins.
- R9: The interrupt is active exactly when bit 2 and bit 5 are both 1. `host_irq_pin` equals the active state when `irq_active_high` is 1, and its inverse when it is 0. Clearing bit 5 does not change bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Host write data |
| host_rd_data | output | 8 | Current register contents |
| irq_active_high | input | 1 | Interrupt pin polarity select, 1 = active high |
| host_irq_pin | output | 1 | Host interrupt pin |
| card_raise_host_irq | input | 1 | Card strobe that raises the card-to-host flag |
| card_ack_card_irq | input | 1 | Card strobe that clears the host-to-card flag |
| card_irq | output | 1 | Host-to-card interrupt flag |
| wdog_expired | input | 1 | Watchdog timeout pulse |
| cpu_halt | output | 1 | Processor reset/halt |
| mem_decode_en | output | 1 | Shared-memory decode enable |
| led_force_red | output | 1 | Health LED forced red when 1 |

## Verification
Every register in the block is one clock deep. A strobe or write sampled at a rising edge therefore appears in the read data and in `card_irq` right after that edge. The interrupt pin, halt, LED and decode enable follow combinationally from that registered state, so they change in the same cycle. The halt hold lasts exactly `HALT_MIN_CYCLES` edges, counted from the edge that clears run. The bench drives all inputs just after a rising edge and advances a behavioural model once per edge. It compares every output one time unit after the next edge, so each result is checked in the cycle it is due.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int REG_W    = 8;
  localparam int POS_RUN  = 7;
  localparam int POS_MEM  = 6;
  localparam int POS_IEN  = 5;
  localparam int POS_WDT  = 4;
  localparam int POS_HIRQ = 2;
  localparam int POS_CIRQ = 0;

  typedef struct packed {
    logic run;
    logic mem_en;
    logic int_en;
    logic wd_stat;
    logic host_flag;
    logic card_flag;
  } ctrl_view_t;

  // Assemble the host-visible byte; unlisted positions read as zero.
  function automatic logic [REG_W-1:0] pack_view(input ctrl_view_t v);
    logic [REG_W-1:0] b;
    b           = '0;
    b[POS_RUN]  = v.run;
    b[POS_MEM]  = v.mem_en;
    b[POS_IEN]  = v.int_en;
    b[POS_WDT]  = v.wd_stat;
    b[POS_HIRQ] = v.host_flag;
    b[POS_CIRQ] = v.card_flag;
    return b;
  endfunction
endpackage

// File: rtl/hcr_flag.sv
// Single doorbell flag; a set strobe beats a clear strobe in the same cycle.
module hcr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hcr_run_ctrl.sv
// Run bit, latched watchdog status and minimum halt-hold timer.
module hcr_run_ctrl #(
  parameter int HALT_MIN_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic wr_run_i,
  input  logic wdog_expired_i,
  output logic run_o,
  output logic wd_latched_o,
  output logic hold_busy_o,
  output logic halt_o
);
  localparam int CW = $clog2(HALT_MIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(HALT_MIN_CYCLES);

  logic          run_q, run_d;
  logic          wd_q, wd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          run_falls;
  logic          hold_busy;

  assign hold_busy = (cnt_q != CNT_END);
  assign run_falls = run_q & ~run_d;

  always_comb begin
    run_d = run_q;
    if (wr_en_i) run_d = wr_run_i;
  end

  // Status latches only while running and is wiped when run drops.
  always_comb begin
    wd_d = (wd_q | (wdog_expired_i & run_q)) & run_d;
  end

  assign cnt_en = run_falls | hold_busy;

  always_comb begin
    cnt_d = cnt_q;
    if (run_falls)      cnt_d = '0;
    else if (hold_busy) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      wd_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      wd_q  <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_o        = run_q;
  assign wd_latched_o = wd_q;
  assign hold_busy_o  = hold_busy;
  assign halt_o       = ~run_q | wd_q | hold_busy;
endmodule

// File: rtl/hcr_irq_pin.sv
// Gates the host-bound flag with the enable and applies pin polarity.
module hcr_irq_pin (
  input  logic flag_i,
  input  logic enable_i,
  input  logic active_high_i,
  output logic pin_o
);
  logic asserted;
  assign asserted = flag_i & enable_i;
  assign pin_o    = active_high_i ? asserted : ~asserted;
endmodule

// File: rtl/hostcard_ctrl_reg.sv
module hostcard_ctrl_reg
  import hcr_pkg::*;
#(
  parameter int HALT_MIN_CYCLES = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [REG_W-1:0] host_wr_data,
  output logic [REG_W-1:0] host_rd_data,
  input  logic             irq_active_high,
  output logic             host_irq_pin,
  input  logic             card_raise_host_irq,
  input  logic             card_ack_card_irq,
  output logic             card_irq,
  input  logic             wdog_expired,
  output logic             cpu_halt,
  output logic             mem_decode_en,
  output logic             led_force_red
);
  logic       mem_q, mem_d;
  logic       ien_q, ien_d;
  logic       run, wd_latched, hold_busy, halt;
  logic       host_flag, card_flag;
  logic       host_ack, host_raise;
  ctrl_view_t view;

  always_comb begin
    mem_d = mem_q;
    ien_d = ien_q;
    if (host_wr_en) begin
      mem_d = host_wr_data[POS_MEM];
      ien_d = host_wr_data[POS_IEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      ien_q <= ien_d;
    end
  end

  hcr_run_ctrl #(.HALT_MIN_CYCLES(HALT_MIN_CYCLES)) u_run (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (host_wr_en),
    .wr_run_i       (host_wr_data[POS_RUN]),
    .wdog_expired_i (wdog_expired),
    .run_o          (run),
    .wd_latched_o   (wd_latched),
    .hold_busy_o    (hold_busy),
    .halt_o         (halt)
  );

  assign host_ack   = host_wr_en & host_wr_data[POS_HIRQ];
  assign host_raise = host_wr_en & host_wr_data[POS_CIRQ];

  hcr_flag u_to_host (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (card_raise_host_irq),
    .clr_i  (host_ack),
    .flag_o (host_flag)
  );

  hcr_flag u_to_card (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (host_raise),
    .clr_i  (card_ack_card_irq),
    .flag_o (card_flag)
  );

  hcr_irq_pin u_pin (
    .flag_i        (host_flag),
    .enable_i      (ien_q),
    .active_high_i (irq_active_high),
    .pin_o         (host_irq_pin)
  );

  always_comb begin
    view.run       = run;
    view.mem_en    = mem_q;
    view.int_en    = ien_q;
    view.wd_stat   = wd_latched | (run & hold_busy);
    view.host_flag = host_flag;
    view.card_flag = card_flag;
  end

  assign host_rd_data  = pack_view(view);
  assign card_irq      = card_flag;
  assign cpu_halt      = halt;
  assign led_force_red = halt;
  assign mem_decode_en = mem_q;
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int HALT_MIN_CYCLES = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr_en,
  input logic [7:0] host_wr_data,
  input logic [7:0] host_rd_data,
  input logic       irq_active_high,
  input logic       host_irq_pin,
  input logic       card_raise_host_irq,
  input logic       card_ack_card_irq,
  input logic       wdog_expired,
  input logic       cpu_halt
);
  localparam int CW = $clog2(HALT_MIN_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(HALT_MIN_CYCLES);

  logic [CW-1:0] since_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_stop <= '0;
    else if (host_wr_en && !host_wr_data[7] && host_rd_data[7]) since_stop <= '0;
    else if (since_stop < LIM) since_stop <= since_stop + 1'b1;
  end

  p_halt_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_data[7] |-> cpu_halt);

  p_wd_latches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data[7] && wdog_expired && !(host_wr_en && !host_wr_data[7]))
      |=> (host_rd_data[4] && cpu_halt));

  p_wd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_data[7] |-> !host_rd_data[4]);

  p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_stop < LIM) |-> cpu_halt);

  p_card_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    card_raise_host_irq |=> host_rd_data[2]);

  p_host_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_data[2] && !card_raise_host_irq) |=> !host_rd_data[2]);

  p_host_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_data[0]) |=> host_rd_data[0]);

  p_card_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ack_card_irq && !(host_wr_en && host_wr_data[0])) |=> !host_rd_data[0]);

  p_pin_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_pin == (irq_active_high == (host_rd_data[2] && host_rd_data[5])));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data[3] == 1'b0) && (host_rd_data[1] == 1'b0));
endmodule

bind hostcard_ctrl_reg hcr_checker #(.HALT_MIN_CYCLES(HALT_MIN_CYCLES)) u_chk (
  .clk                 (clk),
  .rst_n               (rst_n),
  .host_wr_en          (host_wr_en),
  .host_wr_data        (host_wr_data),
  .host_rd_data        (host_rd_data),
  .irq_active_high     (irq_active_high),
  .host_irq_pin        (host_irq_pin),
  .card_raise_host_irq (card_raise_host_irq),
  .card_ack_card_irq   (card_ack_card_irq),
  .wdog_expired        (wdog_expired),
  .cpu_halt            (cpu_halt)
);

// File: tb/hostcard_ctrl_reg_bench.sv
`timescale 1ns/1ps
module hostcard_ctrl_reg_bench;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr_en;
  logic [7:0] host_wr_data;
  logic [7:0] host_rd_data;
  logic       irq_active_high;
  logic       host_irq_pin;
  logic       card_raise_host_irq;
  logic       card_ack_card_irq;
  logic       card_irq;
  logic       wdog_expired;
  logic       cpu_halt;
  logic       mem_decode_en;
  logic       led_force_red;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference state
  int m_run, m_mem, m_ien, m_wd, m_hf, m_cf, m_cnt;

  always #2.5 clk = ~clk;

  hostcard_ctrl_reg #(.HALT_MIN_CYCLES(HOLD)) u_hostcard_ctrl_reg (
    .clk                 (clk),
    .rst_n               (rst_n),
    .host_wr_en          (host_wr_en),
    .host_wr_data        (host_wr_data),
    .host_rd_data        (host_rd_data),
    .irq_active_high     (irq_active_high),
    .host_irq_pin        (host_irq_pin),
    .card_raise_host_irq (card_raise_host_irq),
    .card_ack_card_irq   (card_ack_card_irq),
    .card_irq            (card_irq),
    .wdog_expired        (wdog_expired),
    .cpu_halt            (cpu_halt),
    .mem_decode_en       (mem_decode_en),
    .led_force_red       (led_force_red)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int hold, wdt, halt, act_irq;
    hold    = (m_cnt < HOLD) ? 1 : 0;
    wdt     = (m_wd != 0 || (m_run != 0 && hold != 0)) ? 1 : 0;
    halt    = (m_run == 0 || m_wd != 0 || hold != 0) ? 1 : 0;
    act_irq = (m_hf != 0 && m_ien != 0) ? 1 : 0;
    chk("R2 run bit", host_rd_data[7], m_run);
    chk("R2 ien bit", host_rd_data[5], m_ien);
    chk("R2 reserved bits", {host_rd_data[3], host_rd_data[1]}, 0);
    chk("R3 mem enable", mem_decode_en, m_mem);
    chk("R3 mem bit", host_rd_data[6], m_mem);
    chk((m_run != 0 && hold != 0) ? "R6 wd status while held" : "R5 wd status",
        host_rd_data[4], wdt);
    chk((hold != 0) ? "R6 halt hold" : "R4 halt", cpu_halt, halt);
    chk("R4 led", led_force_red, halt);
    chk("R7 host flag", host_rd_data[2], m_hf);
    chk("R8 card flag bit", host_rd_data[0], m_cf);
    chk("R8 card_irq", card_irq, m_cf);
    chk("R9 pin", host_irq_pin, irq_active_high ? act_irq : 1 - act_irq);
  endtask

  // one clock: model uses the inputs in place now, then outputs are compared
  task automatic step();
    int wr, n_run, n_wd, n_cnt, n_hf, n_cf, n_mem, n_ien;
    wr    = host_wr_en;
    n_run = (wr != 0) ? host_wr_data[7] : m_run;
    n_mem = (wr != 0) ? host_wr_data[6] : m_mem;
    n_ien = (wr != 0) ? host_wr_data[5] : m_ien;
    n_wd  = ((m_wd != 0 || (wdog_expired && m_run != 0)) && n_run != 0) ? 1 : 0;
    if (m_run != 0 && n_run == 0) n_cnt = 0;
    else if (m_cnt < HOLD)        n_cnt = m_cnt + 1;
    else                          n_cnt = m_cnt;
    if (card_raise_host_irq)               n_hf = 1;
    else if (wr != 0 && host_wr_data[2])   n_hf = 0;
    else                                   n_hf = m_hf;
    if (wr != 0 && host_wr_data[0])        n_cf = 1;
    else if (card_ack_card_irq)            n_cf = 0;
    else                                   n_cf = m_cf;
    @(posedge clk);
    m_run = n_run; m_mem = n_mem; m_ien = n_ien; m_wd = n_wd;
    m_cnt = n_cnt; m_hf = n_hf; m_cf = n_cf;
    #1;
    compare_all();
    host_wr_en = 0; host_wr_data = 8'h00;
    card_raise_host_irq = 0; card_ack_card_irq = 0; wdog_expired = 0;
  endtask

  task automatic hwrite(input logic [7:0] d);
    host_wr_en = 1; host_wr_data = d;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int halt_cycles;
    rst_n = 0; host_wr_en = 0; host_wr_data = 0; irq_active_high = 1;
    card_raise_host_irq = 0; card_ack_card_irq = 0; wdog_expired = 0;
    m_run = 0; m_mem = 0; m_ien = 0; m_wd = 0; m_hf = 0; m_cf = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset read data", host_rd_data, 0);
    chk("R1 reset halt", cpu_halt, 1);
    chk("R1 reset led", led_force_red, 1);
    chk("R1 reset mem", mem_decode_en, 0);
    chk("R1 reset card_irq", card_irq, 0);
    chk("R1 reset pin", host_irq_pin, 0);
    rst_n = 1;
    idle(HOLD + 2);

    // R2: start with run, mem, ien; try to poke bits 4,3,1
    hwrite(8'hFA);
    chk("R2 ignored bits", host_rd_data & 8'h1A, 8'h00);
    chk("R4 running", cpu_halt, 0);

    // R7: raise, write-0 no effect, ack, collision
    card_raise_host_irq = 1; step();
    chk("R9 pin active high", host_irq_pin, 1);
    hwrite(8'hE0);
    chk("R7 write0 keeps flag", host_rd_data[2], 1);
    hwrite(8'hE4);
    chk("R7 ack clears", host_rd_data[2], 0);
    card_raise_host_irq = 1; host_wr_en = 1; host_wr_data = 8'hE4; step();
    chk("R7 raise beats ack", host_rd_data[2], 1);

    // R9: polarity and enable gating
    irq_active_high = 0; idle(1);
    chk("R9 active low pin", host_irq_pin, 0);
    hwrite(8'hC0);
    chk("R9 disabled pin inactive", host_irq_pin, 1);
    chk("R9 flag kept when disabled", host_rd_data[2], 1);
    irq_active_high = 1;
    hwrite(8'hE4);

    // R8
    hwrite(8'hE1);
    chk("R8 host raise", card_irq, 1);
    hwrite(8'hE0);
    chk("R8 write0 keeps", card_irq, 1);
    card_ack_card_irq = 1; step();
    chk("R8 card clear", card_irq, 0);
    card_ack_card_irq = 1; host_wr_en = 1; host_wr_data = 8'hE1; step();
    chk("R8 host set beats clear", card_irq, 1);

    // R5: watchdog
    wdog_expired = 1; step();
    chk("R5 wd latched", host_rd_data[4], 1);
    chk("R5 wd halts", cpu_halt, 1);
    hwrite(8'hE0);
    chk("R5 run=1 keeps wd", host_rd_data[4], 1);
    hwrite(8'h60);
    chk("R5 run=0 clears wd", host_rd_data[4], 0);
    wdog_expired = 1; step();
    chk("R5 pulse while stopped ignored", host_rd_data[4], 0);

    // R6: quick restart is held for HOLD clocks
    hwrite(8'hE0);
    hwrite(8'h60);
    hwrite(8'hE0);
    halt_cycles = 2;
    for (int i = 0; i < 20 && cpu_halt; i++) begin
      step(); halt_cycles++;
    end
    chk("R6 held clocks", halt_cycles >= HOLD ? 1 : 0, 1);
    chk("R6 running after hold", cpu_halt, 0);

    // mixed stimulus
    for (int i = 0; i < 2000; i++) begin
      host_wr_en          = ($urandom_range(0, 3) == 0);
      host_wr_data        = 8'($urandom);
      card_raise_host_irq = ($urandom_range(0, 4) == 0);
      card_ack_card_irq   = ($urandom_range(0, 4) == 0);
      wdog_expired        = ($urandom_range(0, 30) == 0);
      if ($urandom_range(0, 50) == 0) irq_active_high = ~irq_active_high;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule